// File: doc/BRIEF.md
# Packed 3-bit pixel serializer

This block drives a 3-bit colour output (one bit each for red, green and blue) for one display row at a time. It runs on a fast clock at five times the pixel rate. A one-cycle row-start strobe arms it. After a fixed lead of five fast clocks it reads bytes from a byte-wide FIFO through a valid/ready port. Each byte holds two neighbouring pixels, and each pixel stays on the output for exactly five fast clocks. A row is 640 pixels, which takes 320 bytes.

Between rows the colour output stays black and no bytes are read. If the FIFO has no data when a byte is due, the block shows that pixel pair as black and sets a sticky underrun flag. A strobe that arrives while a row is still in progress has no effect. Sync timing, the memory that fills the FIFO, and the analogue levels are handled elsewhere.

Top module: `rgb_row_serializer`

## Requirements
- R1: While reset is held and right after it, `rgb` is 0, `in_ready` is 0 and `underrun` is 0.
- R2: With no row in progress, `rgb` stays 0 and `in_ready` stays 0 even when the FIFO presents valid data, so no byte is taken.
- R3: If `row_start` is sampled high at clock edge k, the first pixel is on `rgb` from edge k+5 onward, and `rgb` is 0 after edges k through k+4.
- R4: Bits 2:0 of a byte form the left (first) pixel and bits 5:3 form the right (second) pixel. Bits 7:6 have no effect. On `rgb`, bit 2 is red, bit 1 is green and bit 0 is blue.
- R5: Each pixel value stays on `rgb` for exactly 5 consecutive fast clocks.
- R6: Each accepted strobe outputs exactly 640 pixels and consumes exactly 320 bytes, in FIFO order. After the last pixel, `rgb` returns to 0.
- R7: A `row_start` pulse sampled while a row is in lead or active output is ignored. The row continues unchanged, and no new row follows it.
- R8: If `in_valid` is 0 while `in_ready` is 1, that pixel pair is output as black (0) and no byte is taken. `underrun` rises and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, five cycles per pixel |
| rst | input | 1 | Synchronous active-high reset |
| row_start | input | 1 | One-cycle strobe that begins a row |
| in_data | input | 8 | FIFO head byte holding two packed pixels |
| in_valid | input | 1 | FIFO holds a byte |
| in_ready | output | 1 | Byte taken at this edge when `in_valid` is also high |
| rgb | output | 3 | Pixel colour: bit 2 red, bit 1 green, bit 0 blue |
| underrun | output | 1 | Sticky flag: a byte was due while the FIFO was empty |

## Verification
The bench drives four rows, each with a different byte pattern whose varied values in bits 7:6 would expose any leak of the spare bits into the colour. The first row is preceded by an idle stretch with a full FIFO, which separates a block that waits for the strobe from one that starts reading early. The second row gets an extra strobe part way through, which separates a strobe that is ignored from one that restarts or extends the row. The third row is fed only 300 bytes, which separates black-on-underrun and the sticky flag from stalling or repeating stale data. Every cycle of every pixel is compared, so a wrong hold length or a wrong lead shows up as a pixel mismatch.

// File: rtl/rowser_pkg.sv
package rowser_pkg;

    localparam int PIX_W  = 3;
    localparam int BYTE_W = 8;

    typedef logic [PIX_W-1:0] pix_t;

    typedef enum logic [1:0] {
        RS_IDLE   = 2'd0,
        RS_LEAD   = 2'd1,
        RS_ACTIVE = 2'd2
    } rs_state_e;

    typedef struct packed {
        pix_t right;
        pix_t left;
    } pix_pair_t;

    // Left pixel sits in the low field, right pixel in the next one up.
    function automatic pix_pair_t unpack_pair(input logic [2*PIX_W-1:0] b);
        pix_pair_t p;
        p.left  = b[PIX_W-1:0];
        p.right = b[2*PIX_W-1:PIX_W];
        return p;
    endfunction

endpackage

// File: rtl/rowser_seq.sv
module rowser_seq
    import rowser_pkg::*;
#(
    parameter int ROW_PIXELS  = 640,
    parameter int HOLD_CYCLES = 5,
    parameter int START_DELAY = 5,
    localparam int PH_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1,
    localparam int PX_W = $clog2(ROW_PIXELS),
    localparam int LD_W = $clog2(START_DELAY + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            row_start,
    output rs_state_e       state,
    output logic [PH_W-1:0] phase,
    output logic [PX_W-1:0] pix_idx,
    output logic            fetch,
    output logic            show_right,
    output logic            end_row
);

    logic [LD_W-1:0] lead_q;
    logic            pix_done;
    logic            last_pix;
    logic            lead_done;

    assign lead_done  = (state == RS_LEAD) && (lead_q == LD_W'(START_DELAY - 1));
    assign pix_done   = (state == RS_ACTIVE) && (phase == PH_W'(HOLD_CYCLES - 1));
    assign last_pix   = (pix_idx == PX_W'(ROW_PIXELS - 1));
    assign fetch      = lead_done || (pix_done && pix_idx[0] && !last_pix);
    assign show_right = pix_done && !pix_idx[0];
    assign end_row    = pix_done && last_pix;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RS_IDLE;
            lead_q  <= '0;
            phase   <= '0;
            pix_idx <= '0;
        end else begin
            unique case (state)
                RS_IDLE: begin
                    if (row_start) begin
                        state  <= RS_LEAD;
                        lead_q <= '0;
                    end
                end
                RS_LEAD: begin
                    lead_q <= lead_q + 1'b1;
                    if (lead_done) begin
                        state   <= RS_ACTIVE;
                        phase   <= '0;
                        pix_idx <= '0;
                    end
                end
                RS_ACTIVE: begin
                    if (pix_done) begin
                        phase <= '0;
                        if (last_pix) begin
                            state   <= RS_IDLE;
                            pix_idx <= '0;
                        end else begin
                            pix_idx <= pix_idx + 1'b1;
                        end
                    end else begin
                        phase <= phase + 1'b1;
                    end
                end
                default: state <= RS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rowser_pixreg.sv
module rowser_pixreg
    import rowser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch,
    input  logic              show_right,
    input  logic              end_row,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output pix_t              rgb,
    output logic              underrun
);

    pix_pair_t pair_now;
    pix_t      right_q;
    logic      unused_top_bits;

    assign pair_now        = unpack_pair(in_data[2*PIX_W-1:0]);
    assign unused_top_bits = ^in_data[BYTE_W-1:2*PIX_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            rgb      <= '0;
            right_q  <= '0;
            underrun <= 1'b0;
        end else if (fetch) begin
            if (in_valid) begin
                rgb     <= pair_now.left;
                right_q <= pair_now.right;
            end else begin
                rgb      <= '0;
                right_q  <= '0;
                underrun <= 1'b1;
            end
        end else if (show_right) begin
            rgb <= right_q;
        end else if (end_row) begin
            rgb <= '0;
        end
    end

endmodule

// File: rtl/rgb_row_serializer.sv
module rgb_row_serializer
    import rowser_pkg::*;
#(
    parameter int ROW_PIXELS  = 640,
    parameter int HOLD_CYCLES = 5,
    parameter int START_DELAY = 5,
    localparam int PH_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1,
    localparam int PX_W = $clog2(ROW_PIXELS)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       row_start,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    output logic       in_ready,
    output logic [2:0] rgb,
    output logic       underrun
);

    rs_state_e       seq_state;
    logic [PH_W-1:0] seq_phase;
    logic [PX_W-1:0] seq_pix;
    logic            fetch;
    logic            show_right;
    logic            end_row;

    rowser_seq #(
        .ROW_PIXELS (ROW_PIXELS),
        .HOLD_CYCLES(HOLD_CYCLES),
        .START_DELAY(START_DELAY)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .row_start (row_start),
        .state     (seq_state),
        .phase     (seq_phase),
        .pix_idx   (seq_pix),
        .fetch     (fetch),
        .show_right(show_right),
        .end_row   (end_row)
    );

    rowser_pixreg u_pix (
        .clk       (clk),
        .rst       (rst),
        .fetch     (fetch),
        .show_right(show_right),
        .end_row   (end_row),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .rgb       (rgb),
        .underrun  (underrun)
    );

    assign in_ready = fetch;

endmodule

// File: rtl/rowser_chk.sv
module rowser_chk
    import rowser_pkg::*;
#(
    parameter int ROW_PIXELS  = 640,
    parameter int HOLD_CYCLES = 5,
    localparam int PH_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1,
    localparam int PX_W = $clog2(ROW_PIXELS)
) (
    input logic            clk,
    input logic            rst,
    input rs_state_e       state,
    input logic [PH_W-1:0] phase,
    input logic [PX_W-1:0] pix_idx,
    input logic [2:0]      rgb,
    input logic            in_ready,
    input logic            in_valid,
    input logic            underrun
);

    assert_black_outside_row_R2: assert property (@(posedge clk) disable iff (rst)
        (state != RS_ACTIVE) |-> (rgb == 3'b000));

    assert_no_read_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (state != RS_IDLE));

    assert_pixel_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (state == RS_ACTIVE && phase != '0) |-> $stable(rgb));

    assert_pixel_bound_R6: assert property (@(posedge clk) disable iff (rst)
        pix_idx < PX_W'(ROW_PIXELS));

    assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);

    assert_underrun_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun) |-> $past(in_ready && !in_valid));

endmodule

bind rgb_row_serializer rowser_chk #(
    .ROW_PIXELS (ROW_PIXELS),
    .HOLD_CYCLES(HOLD_CYCLES)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .state   (seq_state),
    .phase   (seq_phase),
    .pix_idx (seq_pix),
    .rgb     (rgb),
    .in_ready(in_ready),
    .in_valid(in_valid),
    .underrun(underrun)
);

// File: tb/tb_rgb_row_serializer.sv
module tb_rgb_row_serializer;

    localparam int ROW  = 640;
    localparam int HOLD = 5;
    localparam int LEAD = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       row_start = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [2:0] rgb;
    logic       underrun;

    int checks = 0;
    int errors = 0;
    int pops   = 0;
    bit pop_now = 1'b0;

    logic [7:0] byte_q [$];
    logic [2:0] exp_q  [$];

    rgb_row_serializer #(.ROW_PIXELS(ROW), .HOLD_CYCLES(HOLD), .START_DELAY(LEAD)) dut (
        .clk(clk), .rst(rst), .row_start(row_start), .in_data(in_data),
        .in_valid(in_valid), .in_ready(in_ready), .rgb(rgb), .underrun(underrun)
    );

    always #10 clk = ~clk;

    // FIFO model: handshake seen at the edge, head updated at the next falling edge
    always @(posedge clk) pop_now <= in_ready && in_valid;
    always @(negedge clk) begin
        if (pop_now) begin
            void'(byte_q.pop_front());
            pops++;
        end
        in_valid = (byte_q.size() != 0);
        in_data  = (byte_q.size() != 0) ? byte_q[0] : 8'h00;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: fills the FIFO and queues the expected pixels (black for missing bytes)
    task automatic load_row(input int n, input int seed);
        for (int i = 0; i < ROW / 2; i++) begin
            if (i < n) begin
                logic [7:0] b;
                b = 8'((i * 37 + seed * 91 + 3) & 255);
                byte_q.push_back(b);
                exp_q.push_back(b[2:0]);
                exp_q.push_back(b[5:3]);
            end else begin
                exp_q.push_back(3'b000);
                exp_q.push_back(3'b000);
            end
        end
    endtask

    // Monitor: strobe, lead, 640 pixels each checked on all hold cycles, then black
    task automatic run_row(input int extra_at, input int exp_pops);
        int pops0;
        pops0 = pops;
        @(negedge clk); row_start = 1'b1;
        @(negedge clk); row_start = 1'b0;
        check(rgb == 3'b000, "R3 lead black", int'(rgb), 0);
        for (int i = 1; i < LEAD; i++) begin
            @(negedge clk);
            check(rgb == 3'b000, "R3 lead black", int'(rgb), 0);
        end
        for (int p = 0; p < ROW; p++) begin
            logic [2:0] want;
            logic [2:0] got;
            bit bad;
            want = exp_q.pop_front();
            got  = want;
            bad  = 1'b0;
            for (int c = 0; c < HOLD; c++) begin
                @(negedge clk);
                if (p == extra_at && c == 0) row_start = 1'b1;
                if (p == extra_at && c == 1) row_start = 1'b0;
                if (rgb !== want) begin
                    bad = 1'b1;
                    got = rgb;
                end
            end
            check(!bad, "R4 R5 pixel value and hold", int'(got), int'(want));
        end
        @(negedge clk);
        check(rgb == 3'b000, "R6 black after row", int'(rgb), 0);
        check(pops - pops0 == exp_pops, "R6 bytes per row", pops - pops0, exp_pops);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(rgb == 3'b000, "R1 rgb in reset", int'(rgb), 0);
        check(in_ready == 1'b0, "R1 ready in reset", int'(in_ready), 0);
        check(underrun == 1'b0, "R1 underrun in reset", int'(underrun), 0);
        rst = 1'b0;
        @(negedge clk);
        check(rgb == 3'b000 && underrun == 1'b0, "R1 after reset", int'(rgb), 0);

        // R2: data waiting, no strobe
        load_row(ROW / 2, 1);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            check(rgb == 3'b000 && in_ready == 1'b0, "R2 idle output", int'(rgb), 0);
        end
        check(byte_q.size() == ROW / 2, "R2 nothing consumed", byte_q.size(), ROW / 2);

        run_row(-1, ROW / 2);
        check(underrun == 1'b0, "R8 no underrun on full row", int'(underrun), 0);

        // R7: extra strobe mid-row, then no further row
        load_row(ROW / 2, 2);
        repeat (3) @(negedge clk);
        run_row(100, ROW / 2);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(rgb == 3'b000 && in_ready == 1'b0, "R7 strobe ignored", int'(rgb), 0);
        end

        // R8: FIFO runs dry
        load_row(300, 3);
        repeat (3) @(negedge clk);
        run_row(-1, 300);
        check(underrun == 1'b1, "R8 underrun raised", int'(underrun), 1);

        load_row(ROW / 2, 4);
        repeat (3) @(negedge clk);
        run_row(-1, ROW / 2);
        check(underrun == 1'b1, "R8 underrun sticky", int'(underrun), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule